// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This block sits between a simple host request port and one 256K x 16 asynchronous DRAM with a multiplexed address bus. A host request carries an 18-bit word address, a write flag, 16-bit write data and a two-bit byte mask. The controller turns each request into RAS/CAS strobe sequences. The row half of the address goes out before RAS falls. The column half goes out before CAS falls. A separate CAS strobe serves each byte lane. Reads come back on a response strobe with the captured word.

After reset, the controller waits out the power-up pause. It then runs a series of CAS-before-RAS refresh cycles and only then takes host traffic. After that, an interval timer asks for one CAS-before-RAS refresh per interval. A pending refresh wins over host traffic. An open row is kept open, so later requests to the same row cost one CAS cycle each. The row is closed when a request targets another row, when a refresh is due, or when RAS has been low close to a set limit. Every DRAM timing is a count of system clock cycles, set by a parameter.

The request port follows valid/ready rules. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the host holds the request fields unchanged. `req_ready` may depend on `req_addr`: a request to a row other than the open one is stalled until the page has been closed. The response side has no back-pressure. `rsp_valid` pulses for one cycle for each accepted read.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is asserted, RAS, both CAS strobes, WE and OE are high, the data bus is not driven, `req_ready` is low and `rsp_valid` is low.
- R2: After reset, RAS does not fall for INIT_WAIT_CYC cycles. At least INIT_REFS CAS-before-RAS cycles complete before `req_ready` first rises.
- R3: For an access, the address pins carry `req_addr[17:9]` when RAS falls and `req_addr[8:0]` when CAS falls. Words stored at different rows with the same column stay distinct.
- R4: `req_be[0]` enables the lower CAS strobe, which serves data bits 7:0. `req_be[1]` enables the upper CAS strobe, which serves bits 15:8. A write changes only the enabled lanes. A read returns zero in the disabled lanes.
- R5: At least one CAS-before-RAS refresh is issued per REF_INTERVAL_CYC cycles once initialization is over. Both CAS strobes fall before RAS. The data bus stays undriven and OE stays high for the whole refresh. A due refresh takes priority over host requests.
- R6: RAS stays low for at least RAS_MIN_CYC cycles. Once RAS rises, it stays high for at least RP_CYC cycles.
- R7: Writes are early writes. WE is low and the write data is driven on the clock edge before the one where CAS falls.
- R8: Reads hold WE high and OE low, and never drive the data bus. Data is captured only once RAS has been low RAC_CYC cycles, CAS has been low CAS_CYC cycles, and the column address has been stable AA_CYC cycles.
- R9: Back-to-back accesses to the open row reuse it without a new RAS fall. Between such accesses, CAS stays high for at least CP_CYC cycles.
- R10: A request to a row other than the open one closes the page by raising RAS, then reopens at the new row.
- R11: RAS is never low for more than RAS_MAX_CYC consecutive cycles.
- R12: Each request held with `req_valid` is performed exactly once. Each accepted read gives exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts the request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address: bits 17:9 row, bits 8:0 column |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, zero in masked lanes |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
The main function is driven with full-word writes and reads, with single-lane writes and reads on both lanes, and with addresses at the ends of the range and rows that differ only in their top bit. Together these separate correct row/column multiplexing and lane gating from lane swaps and dropped address bits. A same-row burst and an alternating-row sequence are measured by counting row-open RAS falls. This shows whether the page is reused, or closed when it must be. Long idle stretches with a page left open show whether the open-time limit closes the row before the refresh does. A behavioural DRAM model on the bench tracks strobe ordering, the length of every RAS low and high phase, the ordering of write-enable against CAS, and the refresh count.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int ROW_BITS  = 9;
  localparam int COL_BITS  = 9;
  localparam int WORD_BITS = 16;
  localparam int LANES     = WORD_BITS / 8;

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_ROW_SETUP, S_RCD, S_COL_SETUP,
    S_COL_ACT, S_PAGE, S_PRECHG, S_REF_CAS, S_REF_RAS
  } fsm_t;

  typedef struct packed {
    logic                 write;
    logic [LANES-1:0]     be;
    logic [ROW_BITS-1:0]  row;
    logic [COL_BITS-1:0]  col;
    logic [WORD_BITS-1:0] wdata;
  } acc_t;
endpackage

// File: rtl/fpm_refresh_sched.sv
module fpm_refresh_sched #(
  parameter int INIT_WAIT_CYC    = 40000,
  parameter int INIT_REFS        = 8,
  parameter int REF_INTERVAL_CYC = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_start,
  output logic wait_done,
  output logic ref_due
);
  localparam int WW = $clog2(INIT_WAIT_CYC + 1);
  localparam int IW = $clog2(REF_INTERVAL_CYC + 1);
  localparam int NW = $clog2(INIT_REFS + 1);

  logic [WW-1:0] wait_cnt;
  logic [IW-1:0] int_cnt;
  logic [NW-1:0] init_left;
  logic          ref_pend;
  logic          tick;

  assign wait_done = (wait_cnt == '0);
  assign tick      = wait_done && (int_cnt == IW'(REF_INTERVAL_CYC - 1));
  assign ref_due   = wait_done && (ref_pend || (init_left != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cnt  <= WW'(INIT_WAIT_CYC);
      int_cnt   <= '0;
      init_left <= NW'(INIT_REFS);
      ref_pend  <= 1'b0;
    end else begin
      if (!wait_done) wait_cnt <= wait_cnt - 1'b1;
      if (wait_done) int_cnt <= tick ? '0 : int_cnt + 1'b1;
      if (tick) ref_pend <= 1'b1;
      else if (ref_start) ref_pend <= 1'b0;
      if (ref_start && (init_left != '0)) init_left <= init_left - 1'b1;
    end
  end
endmodule

// File: rtl/fpm_ras_timer.sv
module fpm_ras_timer #(
  parameter int RAS_MIN_CYC = 12,
  parameter int RAC_CYC     = 12,
  parameter int RAS_MAX_CYC = 2000,
  parameter int GUARD       = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic min_met,
  output logic rac_met,
  output logic near_max
);
  localparam int AW = $clog2(RAS_MAX_CYC + 2);
  localparam logic [AW-1:0] SAT = AW'(RAS_MAX_CYC + 1);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)          age <= '0;
    else if (ras_n)      age <= '0;
    else if (age != SAT) age <= age + 1'b1;
  end

  assign min_met  = (age >= AW'(RAS_MIN_CYC));
  assign rac_met  = (age >= AW'(RAC_CYC));
  assign near_max = (age >= AW'(RAS_MAX_CYC - GUARD));
endmodule

// File: rtl/fpm_rd_capture.sv
module fpm_rd_capture #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [LANES-1:0]   be,
  input  logic [8*LANES-1:0] dq_in,
  output logic               rvalid,
  output logic [8*LANES-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= capture;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)       rdata[8*g +: 8] <= '0;
      else if (capture) rdata[8*g +: 8] <= be[g] ? dq_in[8*g +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int INIT_WAIT_CYC    = 40000,
  parameter int INIT_REFS        = 8,
  parameter int REF_INTERVAL_CYC = 3120,
  parameter int RAS_MIN_CYC      = 12,
  parameter int RAS_MAX_CYC      = 2000,
  parameter int RP_CYC           = 8,
  parameter int RCD_CYC          = 4,
  parameter int RAC_CYC          = 12,
  parameter int CAS_CYC          = 3,
  parameter int AA_CYC           = 6,
  parameter int CP_CYC           = 2,
  parameter int CSR_CYC          = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ROW_BITS+COL_BITS-1:0] req_addr,
  input  logic [WORD_BITS-1:0] req_wdata,
  input  logic [LANES-1:0]     req_be,
  output logic                 rsp_valid,
  output logic [WORD_BITS-1:0] rsp_rdata,
  output logic                 dram_ras_n,
  output logic                 dram_lcas_n,
  output logic                 dram_ucas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [ROW_BITS-1:0]  dram_addr,
  inout  wire  [WORD_BITS-1:0] dram_dq
);
  // read hold covers both CAS access and column access from the setup edge
  localparam int RD_HOLD = ((AA_CYC - 1) > CAS_CYC) ? (AA_CYC - 1) : CAS_CYC;
  localparam int GUARD   = RD_HOLD + CP_CYC + 8;
  localparam int WSUM    = RP_CYC + RCD_CYC + RD_HOLD + CP_CYC + CSR_CYC + CAS_CYC;
  localparam int WC_W    = $clog2(WSUM + 1);

  fsm_t                 st;
  acc_t                 cur;
  acc_t                 req_pk;
  logic [WC_W-1:0]      wcnt;
  logic [ROW_BITS-1:0]  open_row;
  logic                 dq_oe;
  logic [WORD_BITS-1:0] dq_out;
  logic                 wait_done, ref_due, ref_start;
  logic                 min_met, rac_met, near_max;
  logic                 acc_fire, row_hit, capture, close_req;

  assign req_pk    = '{write: req_write, be: req_be,
                       row: req_addr[ROW_BITS+COL_BITS-1:COL_BITS],
                       col: req_addr[COL_BITS-1:0], wdata: req_wdata};
  assign row_hit   = (req_pk.row == open_row);
  assign req_ready = ((st == S_IDLE) && wait_done && !ref_due) ||
                     ((st == S_PAGE) && (wcnt == '0) && !ref_due && !near_max && row_hit);
  assign acc_fire  = req_valid && req_ready;
  assign ref_start = (st == S_IDLE) && ref_due;
  assign close_req = ref_due || near_max || (req_valid && !row_hit);
  assign capture   = (st == S_COL_ACT) && (wcnt == '0) && !cur.write && rac_met;
  assign dram_dq   = dq_oe ? dq_out : 'z;

  fpm_refresh_sched #(
    .INIT_WAIT_CYC(INIT_WAIT_CYC), .INIT_REFS(INIT_REFS),
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC)
  ) sched_i (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start),
    .wait_done(wait_done), .ref_due(ref_due)
  );

  fpm_ras_timer #(
    .RAS_MIN_CYC(RAS_MIN_CYC), .RAC_CYC(RAC_CYC),
    .RAS_MAX_CYC(RAS_MAX_CYC), .GUARD(GUARD)
  ) rtmr_i (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n),
    .min_met(min_met), .rac_met(rac_met), .near_max(near_max)
  );

  fpm_rd_capture #(.LANES(LANES)) rcap_i (
    .clk(clk), .rst_n(rst_n), .capture(capture), .be(cur.be),
    .dq_in(dram_dq), .rvalid(rsp_valid), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_INIT;
      cur         <= '0;
      wcnt        <= '0;
      open_row    <= '0;
      dram_ras_n  <= 1'b1;
      dram_lcas_n <= 1'b1;
      dram_ucas_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dq_oe       <= 1'b0;
      dq_out      <= '0;
    end else begin
      if (wcnt != '0) wcnt <= wcnt - 1'b1;
      unique case (st)
        S_INIT: if (wait_done) st <= S_IDLE;
        S_IDLE: begin
          if (ref_due) begin
            dram_lcas_n <= 1'b0;
            dram_ucas_n <= 1'b0;
            wcnt        <= WC_W'(CSR_CYC - 1);
            st          <= S_REF_CAS;
          end else if (acc_fire) begin
            cur       <= req_pk;
            dram_addr <= req_pk.row;
            st        <= S_ROW_SETUP;
          end
        end
        S_ROW_SETUP: begin
          dram_ras_n <= 1'b0;
          open_row   <= cur.row;
          wcnt       <= WC_W'(RCD_CYC - 1);
          st         <= S_RCD;
        end
        S_RCD: if (wcnt == '0) begin
          dram_addr <= cur.col;
          dram_we_n <= !cur.write;
          dram_oe_n <= cur.write;
          dq_oe     <= cur.write;
          dq_out    <= cur.wdata;
          st        <= S_COL_SETUP;
        end
        S_COL_SETUP: begin
          dram_lcas_n <= !cur.be[0];
          dram_ucas_n <= !cur.be[1];
          wcnt        <= cur.write ? WC_W'(CAS_CYC - 1) : WC_W'(RD_HOLD - 1);
          st          <= S_COL_ACT;
        end
        S_COL_ACT: if ((wcnt == '0) && (cur.write || rac_met)) begin
          dram_lcas_n <= 1'b1;
          dram_ucas_n <= 1'b1;
          dram_we_n   <= 1'b1;
          dram_oe_n   <= 1'b1;
          dq_oe       <= 1'b0;
          wcnt        <= WC_W'(CP_CYC - 1);
          st          <= S_PAGE;
        end
        S_PAGE: if (wcnt == '0) begin
          if (close_req) begin
            if (min_met) begin
              dram_ras_n <= 1'b1;
              wcnt       <= WC_W'(RP_CYC - 1);
              st         <= S_PRECHG;
            end
          end else if (acc_fire) begin
            cur       <= req_pk;
            dram_addr <= req_pk.col;
            dram_we_n <= !req_pk.write;
            dram_oe_n <= req_pk.write;
            dq_oe     <= req_pk.write;
            dq_out    <= req_pk.wdata;
            st        <= S_COL_SETUP;
          end
        end
        S_PRECHG: if (wcnt == '0) st <= S_IDLE;
        S_REF_CAS: if (wcnt == '0) begin
          dram_ras_n <= 1'b0;
          st         <= S_REF_RAS;
        end
        S_REF_RAS: if (min_met) begin
          dram_ras_n  <= 1'b1;
          dram_lcas_n <= 1'b1;
          dram_ucas_n <= 1'b1;
          wcnt        <= WC_W'(RP_CYC - 1);
          st          <= S_PRECHG;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int INIT_REFS   = 8,
  parameter int RAS_MIN_CYC = 12,
  parameter int RAS_MAX_CYC = 2000,
  parameter int RP_CYC      = 8,
  parameter int CP_CYC      = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic lcas_n,
  input logic ucas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_ready
);
  logic        cas_any_n;
  logic [15:0] lo_cnt, hi_cnt, cas_hi_cnt;
  logic [3:0]  cbr_cnt;
  logic        prev_ras, cbr_act;

  assign cas_any_n = lcas_n & ucas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0; hi_cnt <= '0; cas_hi_cnt <= '0;
      cbr_cnt <= '0; prev_ras <= 1'b1; cbr_act <= 1'b0;
    end else begin
      prev_ras   <= ras_n;
      lo_cnt     <= ras_n ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt     <= !ras_n ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1);
      cas_hi_cnt <= !cas_any_n ? 16'd0 : ((cas_hi_cnt == 16'hFFFF) ? cas_hi_cnt : cas_hi_cnt + 1'b1);
      if (prev_ras && !ras_n && !cas_any_n) begin
        cbr_act <= 1'b1;
        if (cbr_cnt != 4'hF) cbr_cnt <= cbr_cnt + 1'b1;
      end else if (ras_n) cbr_act <= 1'b0;
    end
  end

  // R6
  a_r6_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_cnt >= 16'(RAS_MIN_CYC));
  // R6
  a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= 16'(RP_CYC));
  // R11
  a_r11_ras_max: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= 16'(RAS_MAX_CYC));
  // R9
  a_r9_cas_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_any_n) && !ras_n) |-> cas_hi_cnt >= 16'(CP_CYC));
  // R7
  a_r7_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_any_n) && !ras_n && !we_n) |-> ($past(!we_n) && $past(dq_oe)));
  // R5
  a_r5_cbr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_act |-> (!dq_oe && oe_n && we_n));
  // R2
  a_r2_init_refs: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cbr_cnt >= 4'(INIT_REFS));
  // R8
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .INIT_REFS(INIT_REFS), .RAS_MIN_CYC(RAS_MIN_CYC),
  .RAS_MAX_CYC(RAS_MAX_CYC), .RP_CYC(RP_CYC), .CP_CYC(CP_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .lcas_n(dram_lcas_n),
  .ucas_n(dram_ucas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
  .dq_oe(dq_oe), .req_ready(req_ready)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;
  localparam int INIT_WAIT = 40000;
  localparam int INIT_REFS = 8;
  localparam int REF_INT   = 3120;
  localparam int RAS_MIN   = 12;
  localparam int RAS_MAX   = 2000;
  localparam int RP        = 8;
  localparam int NVEC      = 17;

  // {write, be[1:0], addr[17:0], wdata[15:0]}
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 2'b11, 18'h00A00, 16'h1234},
    {1'b1, 2'b11, 18'h00A01, 16'h5678},
    {1'b1, 2'b11, 18'h00A02, 16'h9ABC},
    {1'b0, 2'b11, 18'h00A00, 16'h0000},
    {1'b0, 2'b11, 18'h00A01, 16'h0000},
    {1'b1, 2'b01, 18'h00A01, 16'hFFEE},
    {1'b1, 2'b10, 18'h00A02, 16'h77FF},
    {1'b0, 2'b11, 18'h00A01, 16'h0000},
    {1'b0, 2'b11, 18'h00A02, 16'h0000},
    {1'b1, 2'b11, 18'h3FFFF, 16'hBEEF},
    {1'b1, 2'b11, 18'h00001, 16'h0F0F},
    {1'b0, 2'b01, 18'h00A02, 16'h0000},
    {1'b0, 2'b10, 18'h3FFFF, 16'h0000},
    {1'b0, 2'b11, 18'h00001, 16'h0000},
    {1'b0, 2'b11, 18'h0A201, 16'h0000},
    {1'b1, 2'b11, 18'h20001, 16'hAAAA},
    {1'b0, 2'b11, 18'h00001, 16'h0000}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  wire         req_ready, rsp_valid;
  wire  [15:0] rsp_rdata;
  wire         ras_n, lcas_n, ucas_n, we_n, oe_n;
  wire  [8:0]  dram_addr;
  wire  [15:0] dram_dq;

  int tests = 0, fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl #(
    .INIT_WAIT_CYC(INIT_WAIT), .INIT_REFS(INIT_REFS), .REF_INTERVAL_CYC(REF_INT),
    .RAS_MIN_CYC(RAS_MIN), .RAS_MAX_CYC(RAS_MAX), .RP_CYC(RP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(ras_n), .dram_lcas_n(lcas_n), .dram_ucas_n(ucas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(dram_addr), .dram_dq(dram_dq)
  );

  // ---------------- behavioural DRAM model ----------------
  logic [15:0] dmem [logic [17:0]];
  logic [15:0] shadow [logic [17:0]];
  logic [8:0]  row_lat = '0, col_lat = '0;
  logic        p_ras = 1, p_l = 1, p_u = 1, p_we = 1;
  logic [1:0]  mdrv = '0;
  logic [15:0] mdq = '0;
  int cbr_cnt = 0, open_cnt = 0, wr_cas_cnt = 0, early_bad = 0, rsp_cnt = 0;
  int lo_run = 0, hi_run = 0, lo_min = 1 << 30, lo_max = 0, hi_min = 1 << 30;
  int first_fall = -1;

  assign dram_dq[7:0]  = mdrv[0] ? mdq[7:0]  : 8'hzz;
  assign dram_dq[15:8] = mdrv[1] ? mdq[15:8] : 8'hzz;

  function automatic logic [15:0] mget(input logic [17:0] k);
    return dmem.exists(k) ? dmem[k] : 16'h0000;
  endfunction

  function automatic logic [15:0] sget(input logic [17:0] k);
    return shadow.exists(k) ? shadow[k] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (first_fall < 0) first_fall = cyc;
        if (hi_run < hi_min && first_fall != cyc) hi_min = hi_run;
        if (!lcas_n || !ucas_n) cbr_cnt++;
        else begin row_lat = dram_addr; open_cnt++; end
      end
      if (!p_ras && ras_n) begin
        if (lo_run < lo_min) lo_min = lo_run;
        if (lo_run > lo_max) lo_max = lo_run;
      end
      if (!ras_n) begin lo_run++; hi_run = 0; end
      else begin hi_run++; lo_run = 0; end
      if (!ras_n && ((p_l && !lcas_n) || (p_u && !ucas_n))) begin
        col_lat = dram_addr;
        if (!we_n) begin
          logic [15:0] v;
          if (p_l && p_u) wr_cas_cnt++;
          if (p_we) early_bad++;
          v = mget({row_lat, col_lat});
          if (!lcas_n) v[7:0]  = dram_dq[7:0];
          if (!ucas_n) v[15:8] = dram_dq[15:8];
          dmem[{row_lat, col_lat}] = v;
        end
      end
      mdq     = mget({row_lat, col_lat});
      mdrv[0] = !ras_n && !lcas_n && !oe_n && we_n;
      mdrv[1] = !ras_n && !ucas_n && !oe_n && we_n;
      if (rsp_valid) rsp_cnt++;
      p_ras = ras_n; p_l = lcas_n; p_u = ucas_n; p_we = we_n;
    end
  end

  always @(posedge clk) if (rst_n) cyc++;

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 195000) begin
        fails++;
        $display("FAIL watchdog: run hung, actual cycle %0d expected < 195000", cyc);
        summary();
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_true(input string req, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected bound %0d", req, act, exp);
    end
  endtask

  int n_reads = 0, n_writes = 0;

  task automatic do_acc(input logic w, input logic [1:0] be, input logic [17:0] a,
                        input logic [15:0] d, output logic [15:0] q);
    @(negedge clk);
    req_valid = 1; req_write = w; req_be = be; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    q = '0;
    if (w) begin
      logic [15:0] v;
      n_writes++;
      v = sget(a);
      if (be[0]) v[7:0]  = d[7:0];
      if (be[1]) v[15:8] = d[15:8];
      shadow[a] = v;
    end else begin
      n_reads++;
      while (!rsp_valid) @(negedge clk);
      q = rsp_rdata;
    end
  endtask

  initial begin
    logic [15:0] q;
    int base, cbr_init, cyc_init;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 strobes idle", {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'b11111);
    check("R1 ready/rsp low", {req_ready, rsp_valid}, 2'b00);
    rst_n = 1;
    // R2: no host traffic, no RAS during the power-up pause
    repeat (100) @(negedge clk);
    check("R2 ready low in pause", req_ready, 1'b0);
    while (!req_ready) @(negedge clk);
    check_true("R2 pause before first RAS", first_fall >= INIT_WAIT, first_fall, INIT_WAIT);
    check_true("R2 init refreshes", cbr_cnt >= INIT_REFS, cbr_cnt, INIT_REFS);
    cbr_init = cbr_cnt; cyc_init = cyc;

    // table walk: R3 address mux, R4 lanes, R8 read capture
    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      v = VEC[i];
      do_acc(v[36], v[35:34], v[33:16], v[15:0], q);
      if (!v[36]) begin
        logic [15:0] e;
        e = sget(v[33:16]);
        if (!v[34]) e[7:0] = 8'h00;
        if (!v[35]) e[15:8] = 8'h00;
        check((v[35:34] == 2'b11) ? "R3 R8 word read" : "R4 lane read", q, e);
      end
    end

    // R9: same-row burst reuses the open page
    base = open_cnt;
    for (int i = 0; i < 4; i++) do_acc(1'b0, 2'b11, 18'h00A00 + 18'(i), 16'h0, q);
    check_true("R9 page reuse", (open_cnt - base) <= 2, open_cnt - base, 2);
    check("R9 last burst data", q, sget(18'h00A03));

    // R10: alternating rows reopen every time
    base = open_cnt;
    for (int i = 0; i < 4; i++) do_acc(1'b0, 2'b11, (i % 2) ? 18'h3FFFF : 18'h00001, 16'h0, q);
    check_true("R10 row change reopens", (open_cnt - base) >= 4, open_cnt - base, 4);
    check("R10 data after row switch", q, sget(18'h3FFFF));

    // R11: leave pages open across long idle stretches
    for (int i = 0; i < 3; i++) begin
      do_acc(1'b0, 2'b11, 18'h00A01, 16'h0, q);
      repeat (3200) @(negedge clk);
    end
    check("R11 data after idle", q, sget(18'h00A01));
    check_true("R11 RAS low max", lo_max <= RAS_MAX, lo_max, RAS_MAX);

    // R6 timing, R7 ordering, R5 refresh rate, R12 once-only
    check_true("R6 RAS low min", lo_min >= RAS_MIN, lo_min, RAS_MIN);
    check_true("R6 precharge min", hi_min >= RP, hi_min, RP);
    check_true("R7 WE before CAS", early_bad == 0, early_bad, 0);
    check_true("R5 refresh rate", (cbr_cnt - cbr_init) >= ((cyc - cyc_init) / REF_INT) - 1,
               cbr_cnt - cbr_init, ((cyc - cyc_init) / REF_INT) - 1);
    check_true("R12 one response per read", rsp_cnt == n_reads, rsp_cnt, n_reads);
    check_true("R12 one CAS write per write", wr_cas_cnt == n_writes, wr_cas_cnt, n_writes);
    summary();
  end
endmodule